// File: doc/BRIEF.md
# Dual-Clock FIFO with Fall-Through Output

This block carries a stream of words from a write clock domain to a read clock domain. The two clocks may be unrelated or may be the same clock. A word moves only on a rising edge of its own port's clock, and only while that port's enable is high. Storage is a ring of `2**AW` words. The read and write positions cross between the domains as Gray codes through two flip-flop stages.

A level input chooses how the read side presents data, and it must be held steady outside reset. In standard mode every word stays in storage until a read request moves it into the output register. The read-side flag then means "empty" and the write-side flag means "full". In fall-through mode the oldest stored word is moved into the output register without any request, and each read request replaces it with the next word. The read-side flag then means "output holds valid data" and the write-side flag means "space is available". Two more flags warn when storage is nearly drained or nearly filled. Their thresholds come from a preset chosen by a 2-bit code, or from two configuration words written through the write port straight after reset.

Top module: `xclk_fifo`

## Requirements
- R1: While reset is low and right after it is released, the outputs are as follows. In standard mode `rd_flag`=1 (empty), `wr_flag`=0 (not full), `rd_aempty`=1, `wr_afull`=0 and `rd_data`=0. In fall-through mode `rd_flag`=0 (not ready) and `wr_flag`=1 (ready).
- R2: In standard mode, an accepted write into an empty FIFO clears `rd_flag` once the write crosses the synchronizer. `rd_data` keeps its value until a read with `rd_en`=1 loads the word.
- R3: Words leave in the order they were accepted. In standard mode a read while `rd_flag`=1 (empty) leaves `rd_data` unchanged.
- R4: In standard mode, `wr_flag` rises once `2**AW` words are stored. A write while it is high is dropped and never appears at the read side.
- R5: In fall-through mode, the first word written into an empty FIFO appears on `rd_data` with `rd_flag`=1 and no read. Later words appear only when `rd_en`=1 is sampled while `rd_flag`=1.
- R6: In fall-through mode, a read that consumes the last word drops `rd_flag` to 0, and `rd_data` keeps that last word.
- R7: In fall-through mode, `wr_flag`=1 while space remains. Capacity is `2**AW`+1 words, counting the output register. Writes are dropped while `wr_flag`=0.
- R8: At the first write-clock edge after reset release, `sel` is sampled. Code 01 sets both thresholds to 8, code 10 to 16 and code 11 to 64.
- R9: Let N be the number of words in storage, not counting the output register. `rd_aempty`=1 when N is at or below the empty threshold. `wr_afull`=1 when N exceeds `2**AW` minus the full threshold.
- R10: With code 00, the first accepted write after reset gives the empty threshold from `wr_data[AW:0]`. The second gives the full threshold the same way. Neither word is stored, and normal writes start with the third.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write-side clock |
| rclk | input | 1 | Read-side clock |
| rst_n | input | 1 | Asynchronous active-low reset for both sides |
| fwft | input | 1 | 1 = fall-through mode, 0 = standard mode |
| sel | input | 2 | Threshold code, sampled after reset release |
| wr_en | input | 1 | Write request |
| wr_data | input | DW | Write word or threshold configuration word |
| wr_flag | output | 1 | Full (standard) or input-ready (fall-through) |
| wr_afull | output | 1 | Almost-full warning |
| rd_en | input | 1 | Read request |
| rd_data | output | DW | Output register |
| rd_flag | output | 1 | Empty (standard) or output-ready (fall-through) |
| rd_aempty | output | 1 | Almost-empty warning |

## Verification
A write pointer that skips or repeats a step shows up as a wrong word or a wrong order at `rd_data` on the very read that reaches it. It also moves the fill level, so `rd_aempty` or `wr_afull` changes on the wrong count within about four cycles of the affected clock. A wrong threshold or a misdecoded `sel` code appears as a flag that switches one or more words too early or too late during a fill-and-drain sweep. A wrong fall-through state appears as a word that fails to show without a read, or as data that changes when `rd_flag` drops.

// File: rtl/xclk_fifo_pkg.sv
package xclk_fifo_pkg;

    // Configuration progress on the write side
    typedef enum logic [1:0] {
        CFG_GRAB = 2'd0,
        CFG_AE   = 2'd1,
        CFG_AF   = 2'd2,
        CFG_RUN  = 2'd3
    } cfg_state_e;

    // Preset threshold for a select code; 0 means "load from the bus"
    function automatic int unsigned preset_offset(input logic [1:0] code);
        case (code)
            2'b01:   return 8;
            2'b10:   return 16;
            2'b11:   return 64;
            default: return 0;
        endcase
    endfunction

endpackage

// File: rtl/xclk_gray_sync.sv
module xclk_gray_sync #(
    parameter int W = 9
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_gray,
    output logic [W-1:0] q_bin
);

    logic [W-1:0] s1_q, s2_q;
    logic [W-1:0] bin;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s1_q <= '0;
            s2_q <= '0;
        end else begin
            s1_q <= d_gray;
            s2_q <= s1_q;
        end
    end

    // Gray to binary after the second stage
    always_comb begin
        bin[W-1] = s2_q[W-1];
        for (int i = W - 2; i >= 0; i--) begin
            bin[i] = bin[i+1] ^ s2_q[i];
        end
    end

    assign q_bin = bin;

endmodule

// File: rtl/xclk_fifo_mem.sv
module xclk_fifo_mem #(
    parameter int DW = 36,
    parameter int AW = 8
) (
    input  logic          wclk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);

    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] store_q [DEPTH];

    always_ff @(posedge wclk) begin
        if (we) begin
            store_q[waddr] <= wdata;
        end
    end

    assign rdata = store_q[raddr];

endmodule

// File: rtl/xclk_fifo_wr.sv
module xclk_fifo_wr
    import xclk_fifo_pkg::*;
#(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wen,
    input  logic [AW:0]   cfg_data,
    input  logic [1:0]    sel,
    input  logic [AW:0]   rbin_s,
    output logic          mem_we,
    output logic [AW-1:0] mem_addr,
    output logic [AW:0]   wgray,
    output logic          full,
    output logic          afull,
    output logic [AW:0]   ae_off
);

    localparam int              PW      = AW + 1;
    localparam int              DEPTH   = 1 << AW;
    localparam logic [PW-1:0]   DEPTH_P = PW'(DEPTH);

    typedef struct packed {
        cfg_state_e    st;
        logic [PW-1:0] bin;
        logic [PW-1:0] gray;
        logic          full;
        logic          afull;
        logic [PW-1:0] ae_off;
        logic [PW-1:0] af_off;
    } wr_state_t;

    wr_state_t s_q, s_d;
    logic      push;

    always_comb begin
        s_d  = s_q;
        push = 1'b0;
        case (s_q.st)
            CFG_GRAB: begin
                if (sel == 2'b00) begin
                    s_d.st = CFG_AE;
                end else begin
                    s_d.ae_off = PW'(preset_offset(sel));
                    s_d.af_off = PW'(preset_offset(sel));
                    s_d.st     = CFG_RUN;
                end
            end
            CFG_AE: begin
                if (wen) begin
                    s_d.ae_off = cfg_data;
                    s_d.st     = CFG_AF;
                end
            end
            CFG_AF: begin
                if (wen) begin
                    s_d.af_off = cfg_data;
                    s_d.st     = CFG_RUN;
                end
            end
            default: begin
                push = wen && !s_q.full;
            end
        endcase
        s_d.bin   = s_q.bin + PW'(push);
        s_d.gray  = (s_d.bin >> 1) ^ s_d.bin;
        s_d.full  = (s_d.bin[PW-1] != rbin_s[PW-1]) &&
                    (s_d.bin[PW-2:0] == rbin_s[PW-2:0]);
        s_d.afull = (s_d.bin - rbin_s) > (DEPTH_P - s_d.af_off);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{st: CFG_GRAB, bin: '0, gray: '0, full: 1'b0,
                     afull: 1'b0, ae_off: '0, af_off: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign mem_we   = push;
    assign mem_addr = s_q.bin[AW-1:0];
    assign wgray    = s_q.gray;
    assign full     = s_q.full;
    assign afull    = s_q.afull;
    assign ae_off   = s_q.ae_off;

endmodule

// File: rtl/xclk_fifo_rd.sv
module xclk_fifo_rd #(
    parameter int DW = 36,
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ren,
    input  logic          fwft,
    input  logic [AW:0]   wbin_s,
    input  logic [AW:0]   ae_off,
    input  logic [DW-1:0] mem_rdata,
    output logic [AW-1:0] mem_addr,
    output logic [AW:0]   rgray,
    output logic [DW-1:0] rdata,
    output logic          rflag,
    output logic          aempty
);

    localparam int PW = AW + 1;

    typedef struct packed {
        logic [PW-1:0] bin;
        logic [PW-1:0] gray;
        logic          empty;
        logic          ordy;
        logic          aempty;
        logic [DW-1:0] dout;
    } rd_state_t;

    rd_state_t s_q, s_d;
    logic      pop;

    always_comb begin
        s_d = s_q;
        if (fwft) begin
            // Refill the output register whenever it is free or being read
            pop = !s_q.empty && (!s_q.ordy || ren);
            if (pop) begin
                s_d.ordy = 1'b1;
            end else if (ren) begin
                s_d.ordy = 1'b0;
            end
        end else begin
            pop      = ren && !s_q.empty;
            s_d.ordy = 1'b0;
        end
        if (pop) begin
            s_d.dout = mem_rdata;
        end
        s_d.bin    = s_q.bin + PW'(pop);
        s_d.gray   = (s_d.bin >> 1) ^ s_d.bin;
        s_d.empty  = (s_d.bin == wbin_s);
        s_d.aempty = (wbin_s - s_d.bin) <= ae_off;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            s_q <= '{bin: '0, gray: '0, empty: 1'b1, ordy: 1'b0,
                     aempty: 1'b1, dout: '0};
        end else begin
            s_q <= s_d;
        end
    end

    assign mem_addr = s_q.bin[AW-1:0];
    assign rgray    = s_q.gray;
    assign rdata    = s_q.dout;
    assign rflag    = fwft ? s_q.ordy : s_q.empty;
    assign aempty   = s_q.aempty;

endmodule

// File: rtl/xclk_fifo.sv
module xclk_fifo #(
    parameter int DW = 36,
    parameter int AW = 8
) (
    input  logic          wclk,
    input  logic          rclk,
    input  logic          rst_n,
    input  logic          fwft,
    input  logic [1:0]    sel,
    input  logic          wr_en,
    input  logic [DW-1:0] wr_data,
    output logic          wr_flag,
    output logic          wr_afull,
    input  logic          rd_en,
    output logic [DW-1:0] rd_data,
    output logic          rd_flag,
    output logic          rd_aempty
);

    localparam int PW = AW + 1;

    logic [PW-1:0] wgray, rgray;
    logic [PW-1:0] rbin_wclk, wbin_rclk;
    logic [PW-1:0] ae_off;
    logic          mem_we;
    logic [AW-1:0] waddr, raddr;
    logic [DW-1:0] mem_rdata;
    logic          wr_full;

    xclk_gray_sync #(.W(PW)) u_rsync (
        .clk    (wclk),
        .rst_n  (rst_n),
        .d_gray (rgray),
        .q_bin  (rbin_wclk)
    );

    xclk_gray_sync #(.W(PW)) u_wsync (
        .clk    (rclk),
        .rst_n  (rst_n),
        .d_gray (wgray),
        .q_bin  (wbin_rclk)
    );

    xclk_fifo_wr #(.AW(AW)) u_wr (
        .clk      (wclk),
        .rst_n    (rst_n),
        .wen      (wr_en),
        .cfg_data (wr_data[AW:0]),
        .sel      (sel),
        .rbin_s   (rbin_wclk),
        .mem_we   (mem_we),
        .mem_addr (waddr),
        .wgray    (wgray),
        .full     (wr_full),
        .afull    (wr_afull),
        .ae_off   (ae_off)
    );

    xclk_fifo_mem #(.DW(DW), .AW(AW)) u_mem (
        .wclk  (wclk),
        .we    (mem_we),
        .waddr (waddr),
        .wdata (wr_data),
        .raddr (raddr),
        .rdata (mem_rdata)
    );

    xclk_fifo_rd #(.DW(DW), .AW(AW)) u_rd (
        .clk       (rclk),
        .rst_n     (rst_n),
        .ren       (rd_en),
        .fwft      (fwft),
        .wbin_s    (wbin_rclk),
        .ae_off    (ae_off),
        .mem_rdata (mem_rdata),
        .mem_addr  (raddr),
        .rgray     (rgray),
        .rdata     (rd_data),
        .rflag     (rd_flag),
        .aempty    (rd_aempty)
    );

    assign wr_flag = fwft ? !wr_full : wr_full;

endmodule

// File: rtl/xclk_fifo_chk.sv
module xclk_fifo_chk #(
    parameter int DW = 36,
    parameter int AW = 8
) (
    input logic          wclk,
    input logic          rclk,
    input logic          rst_n,
    input logic          fwft,
    input logic          wr_en,
    input logic          rd_en,
    input logic          wr_full,
    input logic          rd_flag,
    input logic [DW-1:0] rd_data,
    input logic [AW:0]   wgray,
    input logic [AW:0]   rgray
);

    // R4
    full_write_blocked_chk: assert property (@(posedge wclk) disable iff (!rst_n)
        wr_full && wr_en |=> $stable(wgray));

    // R3
    wgray_step_chk: assert property (@(posedge wclk) disable iff (!rst_n)
        $countones(wgray ^ $past(wgray)) <= 1);

    // R3
    rgray_step_chk: assert property (@(posedge rclk) disable iff (!rst_n)
        $countones(rgray ^ $past(rgray)) <= 1);

    // R3
    empty_read_hold_chk: assert property (@(posedge rclk) disable iff (!rst_n)
        !fwft && rd_flag && rd_en |=> $stable(rd_data));

    // R6
    fwft_last_hold_chk: assert property (@(posedge rclk) disable iff (!rst_n)
        fwft && $fell(rd_flag) |-> $stable(rd_data));

endmodule

bind xclk_fifo xclk_fifo_chk #(.DW(DW), .AW(AW)) u_chk (
    .wclk    (wclk),
    .rclk    (rclk),
    .rst_n   (rst_n),
    .fwft    (fwft),
    .wr_en   (wr_en),
    .rd_en   (rd_en),
    .wr_full (wr_full),
    .rd_flag (rd_flag),
    .rd_data (rd_data),
    .wgray   (wgray),
    .rgray   (rgray)
);

// File: tb/xclk_fifo_bench.sv
module xclk_fifo_bench;

    localparam int CLK_PERIOD  = 10;
    localparam int RCLK_PERIOD = CLK_PERIOD + 4;
    localparam int DW          = 36;
    localparam int AW          = 8;
    localparam int DEPTH       = 1 << AW;
    localparam int WATCHDOG    = 200000 * CLK_PERIOD;

    logic          wclk = 1'b0;
    logic          rclk = 1'b0;
    logic          rst_n = 1'b0;
    logic          fwft = 1'b0;
    logic [1:0]    sel = 2'b01;
    logic          wr_en = 1'b0;
    logic [DW-1:0] wr_data = '0;
    logic          rd_en = 1'b0;
    logic          wr_flag, wr_afull, rd_flag, rd_aempty;
    logic [DW-1:0] rd_data;

    int n_cmp = 0;
    int n_bad = 0;

    always #(CLK_PERIOD / 2) wclk = ~wclk;
    always #(RCLK_PERIOD / 2) rclk = ~rclk;

    xclk_fifo #(.DW(DW), .AW(AW)) u_xclk_fifo (
        .wclk      (wclk),
        .rclk      (rclk),
        .rst_n     (rst_n),
        .fwft      (fwft),
        .sel       (sel),
        .wr_en     (wr_en),
        .wr_data   (wr_data),
        .wr_flag   (wr_flag),
        .wr_afull  (wr_afull),
        .rd_en     (rd_en),
        .rd_data   (rd_data),
        .rd_flag   (rd_flag),
        .rd_aempty (rd_aempty)
    );

    function automatic logic [DW-1:0] pat(input int i, input int salt);
        return {salt[3:0], 32'(i) * 32'h0001_0003 + 32'h0000_5A5A};
    endfunction

    task automatic chk(input string what, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", what, act, exp);
        end
    endtask

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    endtask

    task automatic do_reset(input logic mode, input logic [1:0] code);
        rst_n = 1'b0;
        wr_en = 1'b0;
        rd_en = 1'b0;
        fwft  = mode;
        sel   = code;
        repeat (4) @(negedge rclk);
        @(negedge wclk);
        rst_n = 1'b1;
        repeat (3) @(negedge wclk);
    endtask

    task automatic push(input logic [DW-1:0] d);
        @(negedge wclk);
        wr_en   = 1'b1;
        wr_data = d;
        @(negedge wclk);
        wr_en   = 1'b0;
    endtask

    task automatic pop();
        @(negedge rclk);
        rd_en = 1'b1;
        @(negedge rclk);
        rd_en = 1'b0;
    endtask

    task automatic settle();
        repeat (8) @(negedge rclk);
    endtask

    // Fill to full and drain again in standard mode, checking the warning flags at every level
    task automatic sweep(input string tag, input int ae_o, input int af_o, input int salt);
        for (int n = 1; n <= DEPTH; n++) begin
            push(pat(n, salt));
            settle();
            chk({tag, " almost-empty on fill"}, 64'(rd_aempty), 64'(n <= ae_o));
            chk({tag, " almost-full on fill"}, 64'(wr_afull), 64'(n > DEPTH - af_o));
        end
        chk("R4 full flag at capacity", 64'(wr_flag), 64'd1);
        push(pat(9999, salt));
        settle();
        for (int k = 1; k <= DEPTH; k++) begin
            pop();
            chk("R3 word order", 64'(rd_data), 64'(pat(k, salt)));
            settle();
            chk({tag, " almost-empty on drain"}, 64'(rd_aempty), 64'((DEPTH - k) <= ae_o));
            chk({tag, " almost-full on drain"}, 64'(wr_afull), 64'((DEPTH - k) > DEPTH - af_o));
        end
        chk("R2 empty after drain", 64'(rd_flag), 64'd1);
        pop();
        chk("R4 write while full dropped", 64'(rd_data), 64'(pat(DEPTH, salt)));
    endtask

    initial begin
        #(WATCHDOG);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        summary();
        $finish;
    end

    initial begin
        // R1 standard-mode reset state
        do_reset(1'b0, 2'b01);
        chk("R1 empty flag", 64'(rd_flag), 64'd1);
        chk("R1 full flag", 64'(wr_flag), 64'd0);
        chk("R1 almost-empty", 64'(rd_aempty), 64'd1);
        chk("R1 almost-full", 64'(wr_afull), 64'd0);
        chk("R1 output register", 64'(rd_data), 64'd0);

        // R2 word stays in storage until read
        push(pat(0, 1));
        settle();
        chk("R2 not empty", 64'(rd_flag), 64'd0);
        chk("R2 output unchanged before read", 64'(rd_data), 64'd0);
        pop();
        chk("R2 read loads word", 64'(rd_data), 64'(pat(0, 1)));
        settle();
        chk("R2 empty again", 64'(rd_flag), 64'd1);

        // R3 read on empty is ignored
        pop();
        settle();
        chk("R3 read on empty keeps data", 64'(rd_data), 64'(pat(0, 1)));

        // R3 ordering with a short burst
        for (int i = 0; i < 20; i++) push(pat(i, 2));
        settle();
        for (int i = 0; i < 20; i++) begin
            pop();
            chk("R3 burst order", 64'(rd_data), 64'(pat(i, 2)));
        end

        // R8 R9 preset codes
        do_reset(1'b0, 2'b01);
        sweep("R8 R9 code01", 8, 8, 3);
        do_reset(1'b0, 2'b10);
        sweep("R8 R9 code10", 16, 16, 4);
        do_reset(1'b0, 2'b11);
        sweep("R8 R9 code11", 64, 64, 5);

        // R10 thresholds loaded through the write port
        do_reset(1'b0, 2'b00);
        push(DW'(5));
        push(DW'(3));
        settle();
        chk("R10 config words not stored", 64'(rd_flag), 64'd1);
        sweep("R10 R9 loaded", 5, 3, 6);

        // R1 fall-through reset state
        do_reset(1'b1, 2'b01);
        chk("R1 fwft not ready", 64'(rd_flag), 64'd0);
        chk("R1 fwft input ready", 64'(wr_flag), 64'd1);

        // R5 first word falls through
        push(pat(0, 7));
        settle();
        chk("R5 output ready", 64'(rd_flag), 64'd1);
        chk("R5 first word shown", 64'(rd_data), 64'(pat(0, 7)));
        push(pat(1, 7));
        push(pat(2, 7));
        settle();
        chk("R5 later words wait", 64'(rd_data), 64'(pat(0, 7)));
        pop();
        chk("R5 read advances", 64'(rd_data), 64'(pat(1, 7)));
        chk("R5 still ready", 64'(rd_flag), 64'd1);
        pop();
        chk("R5 read advances again", 64'(rd_data), 64'(pat(2, 7)));
        pop();
        settle();
        chk("R6 ready drops on last read", 64'(rd_flag), 64'd0);
        chk("R6 last word kept", 64'(rd_data), 64'(pat(2, 7)));

        // R7 fall-through capacity and input-ready
        for (int i = 0; i < DEPTH; i++) push(pat(i, 8));
        settle();
        chk("R7 one slot left", 64'(wr_flag), 64'd1);
        push(pat(DEPTH, 8));
        settle();
        chk("R7 input-ready drops", 64'(wr_flag), 64'd0);
        push(pat(9999, 8));
        settle();
        chk("R7 head word", 64'(rd_data), 64'(pat(0, 8)));
        for (int k = 1; k <= DEPTH; k++) begin
            pop();
            chk("R7 drain order", 64'(rd_data), 64'(pat(k, 8)));
        end
        pop();
        settle();
        chk("R7 extra write dropped", 64'(rd_flag), 64'd0);
        chk("R6 final word kept", 64'(rd_data), 64'(pat(DEPTH, 8)));
        chk("R7 ready after drain", 64'(wr_flag), 64'd1);

        summary();
        $finish;
    end

endmodule